// File: doc/BRIEF.md
# Plane-Wave Focusing Delay Generator

This block serves a delay-and-sum receive beamformer that images with a steered plane-wave transmission. For one image point (lateral position `pixX`, depth `pixZ`) and one receive element (`elemIdx`), it computes the RF sample index from which that element's echo for the point is read. It also gives the receive apodization weight for that element and a flag that says whether the contribution should be used at all. All geometry is in signed or unsigned integer distance ticks. A tick is the unit in which the element pitch is expressed, and `ADDR_SHIFT` ticks of round-trip path equal one sample period.

The path length has two parts. The transmit part follows a plane wavefront tilted by the steering angle `steerDeg`, given in whole degrees. The receive part is the straight-line distance from the point back to the element, and a sixteen-step integer square root evaluates it. The block withholds the element when it sits outside a 45-degree cone below the point, measured from a programmable minimum depth. It also withholds the element when the resulting index falls past the end of the stored record. Every other element is weighted by a Hann taper whose full span is twice the array width, centred on the pixel.

A request is made by a one-cycle `start` pulse while the block is idle. The result appears together with a one-cycle `done` pulse and stays on the outputs until the next result. The caller iterates pixels and elements and accumulates the weighted samples elsewhere.

Top module: `pw_focus_delay`

## Requirements
- R1: While `rstN` is low at a rising edge (synchronous, active low), the block returns to idle, and afterwards `done`, `addrOk`, `sampleAddr` and `apodW` are all 0.
- R2: A `start` sampled high while idle produces exactly one `done` pulse, one cycle long, visible after the 18th rising edge following the sampling edge. The new result is on the outputs in that same cycle.
- R3: A `start` that arrives while a computation is in flight, including the edge that delivers the result, is ignored: the pending result is unchanged and no extra `done` occurs. A `start` on the first edge after `done` is accepted.
- R4: `sampleAddr`, `apodW` and `addrOk` change only at the edge that raises `done`, and hold their values between results.
- R5: Element j sits at xj = ((j+1) − N_ELEM/2)·PITCH (defaults 128 and 80). The receive distance is floor(sqrt(z² + (xj − x)²)), exact for any radicand below 2^32.
- R6: The transmit distance is (z·C + x·S + (N_ELEM·PITCH/2)·|S| + 2^14) >>> 15, an arithmetic shift. C = round(32767·cos θ) and |S| = round(32767·sin|θ|), and S takes the sign of θ.
- R7: With total = transmit + receive distance, the candidate address is total >>> ADDR_SHIFT (default 3). At zero steering this is (receive + z)/8 up to the rounding of R6.
- R8: The steering angle is saturated to ±MAX_STEER degrees (default 30) before the sine and cosine are looked up, for any value of the 7-bit signed input.
- R9: The result is invalid when z < Z_START (default 64) or |xj − x| > z − Z_START. Equality is still valid.
- R10: The result is invalid when total < 0 or the candidate address is not below REC_LEN (default 6025).
- R11: An invalid result drives `addrOk` = 0, `sampleAddr` = 0 and `apodW` = 0. A valid one drives `addrOk` = 1 with the candidate address.
- R12: For a valid result, `apodW` = round(65535·cos²(π·k/512)) with k = floor(|xj − x| / APOD_STEP), where APOD_STEP = N_ELEM·PITCH/256 = 40. The weight is 0 when k ≥ 256, and the result stays valid in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request strobe, honoured only when idle |
| pixX | input | 16 | Pixel lateral position, signed ticks |
| pixZ | input | 15 | Pixel depth, unsigned ticks |
| elemIdx | input | 7 | Receive element index |
| steerDeg | input | 7 | Steering angle, signed whole degrees |
| sampleAddr | output | 13 | RF sample index to read, 0 when invalid |
| apodW | output | 16 | Hann weight in Q0.16, 0 when invalid |
| addrOk | output | 1 | Contribution valid |
| done | output | 1 | One-cycle result strobe |

## Verification
The in-line assertions check four things on every cycle. `done` never lasts two cycles, and the result edge always follows a square-root step. The outputs move only on the result edge. An invalid result always carries a zero address and weight, and a valid one never points past the record. The numerical content needs the bench's independent model to show: the exact root, the transmit rounding for positive, negative and saturated angles, the directivity boundary at equality, the record-end cut-off and the taper values. So does the rejection of a request that lands on the result edge.

// File: rtl/pw_focus_pkg.sv
package pw_focus_pkg;

  typedef struct packed {
    logic loadIn;
    logic prep;
    logic rootStep;
    logic finish;
  } focusStrobes_t;

  localparam real PI_C = 3.14159265358979;

  // Q1.15 sine or cosine of a whole-degree angle, rounded to nearest.
  function automatic int trigQ15(input int deg, input bit wantCos);
    real ang;
    ang = real'(deg) * PI_C / 180.0;
    if (wantCos) return int'($cos(ang) * 32767.0);
    return int'($sin(ang) * 32767.0);
  endfunction

  // Cosine-squared taper sample k of depth entries, full scale 2^wBits-1.
  function automatic int hannQ(input int k, input int depth, input int wBits);
    real c;
    c = $cos(PI_C * real'(k) / real'(2 * depth));
    return int'(c * c * real'((1 << wBits) - 1));
  endfunction

endpackage

// File: rtl/pw_focus_tables.sv
module pw_focus_tables
  import pw_focus_pkg::*;
#(
  parameter int MAX_STEER  = 30,
  parameter int HANN_DEPTH = 256,
  parameter int W_W        = 16,
  localparam int ANG_W     = $clog2(MAX_STEER + 1),
  localparam int HIDX_W    = $clog2(HANN_DEPTH)
) (
  input  logic [ANG_W-1:0]  angIdx,
  input  logic [HIDX_W-1:0] hannIdx,
  output logic [15:0]       sinMag,
  output logic [15:0]       cosMag,
  output logic [W_W-1:0]    hannW
);

  logic [15:0]    sinTab  [0:MAX_STEER];
  logic [15:0]    cosTab  [0:MAX_STEER];
  logic [W_W-1:0] hannTab [0:HANN_DEPTH-1];

  for (genvar g = 0; g <= MAX_STEER; g++) begin : g_trig
    localparam logic [15:0] SIN_V = 16'(trigQ15(g, 1'b0));
    localparam logic [15:0] COS_V = 16'(trigQ15(g, 1'b1));
    assign sinTab[g] = SIN_V;
    assign cosTab[g] = COS_V;
  end

  for (genvar h = 0; h < HANN_DEPTH; h++) begin : g_hann
    localparam logic [W_W-1:0] HANN_V = W_W'(hannQ(h, HANN_DEPTH, W_W));
    assign hannTab[h] = HANN_V;
  end

  assign sinMag = sinTab[angIdx];
  assign cosMag = cosTab[angIdx];
  assign hannW  = hannTab[hannIdx];

endmodule

// File: rtl/pw_focus_ctrl.sv
module pw_focus_ctrl
  import pw_focus_pkg::*;
#(
  parameter int ROOT_W = 16,
  localparam int CNT_W = $clog2(ROOT_W)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output focusStrobes_t st,
  output logic          done
);

  typedef enum logic [1:0] {S_IDLE, S_PREP, S_ROOT, S_FIN} ctrlState_t;

  ctrlState_t       state;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    st          = '0;
    st.loadIn   = (state == S_IDLE) && start;
    st.prep     = (state == S_PREP);
    st.rootStep = (state == S_ROOT);
    st.finish   = (state == S_FIN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= st.finish;
      unique case (state)
        S_IDLE: if (start) state <= S_PREP;
        S_PREP: begin
          stepCnt <= '0;
          state   <= S_ROOT;
        end
        S_ROOT: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == CNT_W'(ROOT_W - 1)) state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2
  finish_after_root_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.finish |-> $past(st.rootStep));

endmodule

// File: rtl/pw_focus_dp.sv
module pw_focus_dp
  import pw_focus_pkg::*;
#(
  parameter int N_ELEM     = 128,
  parameter int PITCH      = 80,
  parameter int X_W        = 16,
  parameter int Z_W        = 15,
  parameter int DEG_W      = 7,
  parameter int MAX_STEER  = 30,
  parameter int ROOT_W     = 16,
  parameter int ADDR_SHIFT = 3,
  parameter int REC_LEN    = 6025,
  parameter int Z_START    = 64,
  parameter int HANN_DEPTH = 256,
  parameter int W_W        = 16,
  localparam int ELEM_W    = $clog2(N_ELEM),
  localparam int ANG_W     = $clog2(MAX_STEER + 1),
  localparam int HIDX_W    = $clog2(HANN_DEPTH),
  localparam int ADDR_W    = $clog2(REC_LEN),
  localparam int RAD_W     = 2 * ROOT_W,
  localparam int TX_W      = ROOT_W + 3,
  localparam int HALF_AP   = N_ELEM * PITCH / 2,
  localparam int APOD_STEP = N_ELEM * PITCH / HANN_DEPTH
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  focusStrobes_t           st,
  input  logic signed [X_W-1:0]   pixX,
  input  logic [Z_W-1:0]          pixZ,
  input  logic [ELEM_W-1:0]       elemIdx,
  input  logic signed [DEG_W-1:0] steerDeg,
  output logic [ANG_W-1:0]        angIdx,
  output logic [HIDX_W-1:0]       hannIdx,
  input  logic [15:0]             sinMag,
  input  logic [15:0]             cosMag,
  input  logic [W_W-1:0]          hannW,
  output logic [ADDR_W-1:0]       sampleAddr,
  output logic [W_W-1:0]          apodW,
  output logic                    addrOk
);

  // captured request
  logic signed [X_W-1:0] xR;
  logic [Z_W-1:0]        zR;
  logic [ELEM_W-1:0]     elemR;
  logic                  angNegR;

  // prepared geometry
  logic signed [TX_W-1:0] txR;
  logic                   dirOkR;
  logic [W_W-1:0]         wR;

  // square-root state
  logic [RAD_W-1:0]  radA;
  logic [ROOT_W-1:0] rootQ;
  logic [ROOT_W+1:0] rootR;

  // angle saturation on capture
  int   degMag;
  logic degNeg;
  always_comb begin
    degNeg = steerDeg < 0;
    degMag = degNeg ? -int'(steerDeg) : int'(steerDeg);
    if (degMag > MAX_STEER) degMag = MAX_STEER;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xR      <= '0;
      zR      <= '0;
      elemR   <= '0;
      angIdx  <= '0;
      angNegR <= 1'b0;
    end else if (st.loadIn) begin
      xR      <= pixX;
      zR      <= pixZ;
      elemR   <= elemIdx;
      angIdx  <= ANG_W'(degMag);
      angNegR <= degNeg;
    end
  end

  // geometry of the captured request
  int      elemPos, dx, absDx, hannFull;
  longint  radSum, txSum, sinSgn;
  logic    dirOk, hannIn;
  always_comb begin
    elemPos  = (int'(elemR) + 1 - N_ELEM / 2) * PITCH;
    dx       = elemPos - int'(xR);
    absDx    = (dx < 0) ? -dx : dx;
    radSum   = longint'(int'(zR)) * longint'(int'(zR)) + longint'(dx) * longint'(dx);
    sinSgn   = angNegR ? -longint'(int'(sinMag)) : longint'(int'(sinMag));
    txSum    = longint'(int'(zR)) * longint'(int'(cosMag))
             + longint'(int'(xR)) * sinSgn
             + longint'(HALF_AP) * longint'(int'(sinMag))
             + longint'(1 << 14);
    dirOk    = (int'(zR) >= Z_START) && (absDx <= int'(zR) - Z_START);
    hannFull = absDx / APOD_STEP;
    hannIn   = hannFull < HANN_DEPTH;
    hannIdx  = hannIn ? HIDX_W'(hannFull) : '0;
  end

  // non-restoring root step
  logic [ROOT_W+1:0] rootLeft, rootRight, rootNext;
  always_comb begin
    rootRight = {rootQ, rootR[ROOT_W+1], 1'b1};
    rootLeft  = {rootR[ROOT_W-1:0], radA[RAD_W-1 -: 2]};
    rootNext  = rootR[ROOT_W+1] ? (rootLeft + rootRight) : (rootLeft - rootRight);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txR    <= '0;
      dirOkR <= 1'b0;
      wR     <= '0;
      radA   <= '0;
      rootQ  <= '0;
      rootR  <= '0;
    end else if (st.prep) begin
      txR    <= TX_W'(txSum >>> 15);
      dirOkR <= dirOk;
      wR     <= hannIn ? hannW : '0;
      radA   <= RAD_W'(radSum);
      rootQ  <= '0;
      rootR  <= '0;
    end else if (st.rootStep) begin
      radA  <= radA << 2;
      rootR <= rootNext;
      rootQ <= {rootQ[ROOT_W-2:0], ~rootNext[ROOT_W+1]};
    end
  end

  // final address and gating
  int   total, addrFull;
  logic resOk;
  always_comb begin
    total    = int'(txR) + int'(rootQ);
    addrFull = total >>> ADDR_SHIFT;
    resOk    = dirOkR && (total >= 0) && (addrFull < REC_LEN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleAddr <= '0;
      apodW      <= '0;
      addrOk     <= 1'b0;
    end else if (st.finish) begin
      sampleAddr <= resOk ? ADDR_W'(addrFull) : '0;
      apodW      <= resOk ? wR : '0;
      addrOk     <= resOk;
    end
  end

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.finish |=> ($stable(sampleAddr) && $stable(apodW) && $stable(addrOk)));

  // R10
  addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrOk |-> (int'(sampleAddr) < REC_LEN));

  // R11
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !addrOk |-> (sampleAddr == '0 && apodW == '0));

  // R9
  dir_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.finish && !dirOkR) |=> !addrOk);

endmodule

// File: rtl/pw_focus_delay.sv
module pw_focus_delay
  import pw_focus_pkg::*;
#(
  parameter int N_ELEM     = 128,
  parameter int PITCH      = 80,
  parameter int X_W        = 16,
  parameter int Z_W        = 15,
  parameter int DEG_W      = 7,
  parameter int MAX_STEER  = 30,
  parameter int ROOT_W     = 16,
  parameter int ADDR_SHIFT = 3,
  parameter int REC_LEN    = 6025,
  parameter int Z_START    = 64,
  parameter int HANN_DEPTH = 256,
  parameter int W_W        = 16,
  localparam int ELEM_W    = $clog2(N_ELEM),
  localparam int ANG_W     = $clog2(MAX_STEER + 1),
  localparam int HIDX_W    = $clog2(HANN_DEPTH),
  localparam int ADDR_W    = $clog2(REC_LEN)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic signed [X_W-1:0]   pixX,
  input  logic [Z_W-1:0]          pixZ,
  input  logic [ELEM_W-1:0]       elemIdx,
  input  logic signed [DEG_W-1:0] steerDeg,
  output logic [ADDR_W-1:0]       sampleAddr,
  output logic [W_W-1:0]          apodW,
  output logic                    addrOk,
  output logic                    done
);

  focusStrobes_t      st;
  logic [ANG_W-1:0]   angIdx;
  logic [HIDX_W-1:0]  hannIdx;
  logic [15:0]        sinMag, cosMag;
  logic [W_W-1:0]     hannW;

  pw_focus_ctrl #(.ROOT_W(ROOT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .st(st), .done(done)
  );

  pw_focus_tables #(
    .MAX_STEER(MAX_STEER), .HANN_DEPTH(HANN_DEPTH), .W_W(W_W)
  ) u_tables (
    .angIdx(angIdx), .hannIdx(hannIdx),
    .sinMag(sinMag), .cosMag(cosMag), .hannW(hannW)
  );

  pw_focus_dp #(
    .N_ELEM(N_ELEM), .PITCH(PITCH), .X_W(X_W), .Z_W(Z_W), .DEG_W(DEG_W),
    .MAX_STEER(MAX_STEER), .ROOT_W(ROOT_W), .ADDR_SHIFT(ADDR_SHIFT),
    .REC_LEN(REC_LEN), .Z_START(Z_START), .HANN_DEPTH(HANN_DEPTH), .W_W(W_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st),
    .pixX(pixX), .pixZ(pixZ), .elemIdx(elemIdx), .steerDeg(steerDeg),
    .angIdx(angIdx), .hannIdx(hannIdx),
    .sinMag(sinMag), .cosMag(cosMag), .hannW(hannW),
    .sampleAddr(sampleAddr), .apodW(apodW), .addrOk(addrOk)
  );

endmodule

// File: tb/pw_focus_delay_bench.sv
module pw_focus_delay_bench;

  localparam int  NE = 128, PT = 80, MAXS = 30, ZS = 64, REC = 6025;
  localparam int  SHIFT = 3, STEP = 40, HD = 256;
  localparam real PI = 3.14159265358979;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               start = 1'b0;
  logic signed [15:0] pixX = '0;
  logic [14:0]        pixZ = '0;
  logic [6:0]         elemIdx = '0;
  logic signed [6:0]  steerDeg = '0;
  logic [12:0]        sampleAddr;
  logic [15:0]        apodW;
  logic               addrOk;
  logic               done;

  always #5 clk = ~clk;

  pw_focus_delay u_pw_focus_delay (
    .clk(clk), .rstN(rstN), .start(start), .pixX(pixX), .pixZ(pixZ),
    .elemIdx(elemIdx), .steerDeg(steerDeg), .sampleAddr(sampleAddr),
    .apodW(apodW), .addrOk(addrOk), .done(done)
  );

  int    checks = 0, errors = 0, cyc = 0, tgt = -1;
  int    expA = 0, expW = 0, expV = 0, heldA = 0, heldW = 0, heldV = 0;
  string curTag = "R2";
  bit    monOn = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic longint isqrt(input longint v);
    longint r;
    r = longint'($sqrt(real'(v)));
    while (r * r > v) r--;
    while ((r + 1) * (r + 1) <= v) r++;
    return r;
  endfunction

  // reference from the requirements
  task automatic model(input int x, input int z, input int e, input int d,
                       output int a, output int w, output int v);
    int d2, ad, s, c, sg, xj, dx, adx, k, tot, ad8;
    longint tx, rx;
    bit ok;
    d2  = (d > MAXS) ? MAXS : ((d < -MAXS) ? -MAXS : d);          // R8
    ad  = (d2 < 0) ? -d2 : d2;
    s   = int'($sin(real'(ad) * PI / 180.0) * 32767.0);
    c   = int'($cos(real'(ad) * PI / 180.0) * 32767.0);
    sg  = (d2 < 0) ? -s : s;
    tx  = (longint'(z) * c + longint'(x) * sg + longint'(NE * PT / 2) * s + 16384) >>> 15; // R6
    xj  = ((e + 1) - NE / 2) * PT;                                 // R5
    dx  = xj - x;
    adx = (dx < 0) ? -dx : dx;
    rx  = isqrt(longint'(z) * z + longint'(dx) * dx);
    tot = int'(tx + rx);
    ad8 = tot >>> SHIFT;                                           // R7
    ok  = (z >= ZS) && (adx <= z - ZS) && (tot >= 0) && (ad8 < REC); // R9 R10
    k   = adx / STEP;
    if (k < HD) begin
      real cc;
      cc = $cos(PI * real'(k) / real'(2 * HD));
      w  = int'(cc * cc * 65535.0);                                // R12
    end else w = 0;
    a = ok ? ad8 : 0;                                              // R11
    if (!ok) w = 0;
    v = ok ? 1 : 0;
  endtask

  // per-cycle comparison against the held model
  always @(negedge clk) begin
    bit expDone;
    if (monOn) begin
      expDone = (cyc == tgt);
      if (expDone) begin
        heldA = expA; heldW = expW; heldV = expV;
      end
      chk(done == expDone, "R2", "done", int'(done), int'(expDone));
      chk(int'(sampleAddr) == heldA, expDone ? curTag : "R4", "sampleAddr", int'(sampleAddr), heldA);
      chk(int'(apodW) == heldW, expDone ? curTag : "R4", "apodW", int'(apodW), heldW);
      chk(int'(addrOk) == heldV, expDone ? curTag : "R4", "addrOk", int'(addrOk), heldV);
    end
  end

  task automatic drive(input int x, input int z, input int e, input int d);
    pixX = 16'(x); pixZ = 15'(z); elemIdx = 7'(e); steerDeg = 7'(d);
    start = 1'b1;
  endtask

  // called at a negedge; returns at the following negedge
  task automatic issue(input int x, input int z, input int e, input int d, input string tag);
    int a, w, v;
    model(x, z, e, d, a, w, v);
    drive(x, z, e, d);
    expA <= a; expW <= w; expV <= v; curTag <= tag;
    tgt  <= cyc + 19;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic ghost(input int x, input int z, input int e, input int d);
    drive(x, z, e, d);
    @(negedge clk) start = 1'b0;
  endtask

  task automatic waitIdle();
    while (cyc <= tgt) @(negedge clk);
  endtask

  task automatic run(input int x, input int z, input int e, input int d, input string tag);
    issue(x, z, e, d, tag);
    waitIdle();
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(done == 1'b0, "R1", "done", int'(done), 0);
    chk(addrOk == 1'b0, "R1", "addrOk", int'(addrOk), 0);
    chk(sampleAddr == '0, "R1", "sampleAddr", int'(sampleAddr), 0);
    chk(apodW == '0, "R1", "apodW", int'(apodW), 0);
    rstN = 1'b1;
    monOn = 1'b1;
    @(negedge clk);

    run(0, 4000, 63, 0, "R7");          // on-axis, zero steer
    run(1000, 3000, 70, 0, "R5");       // element offset
    run(-800, 5000, 40, 15, "R6");      // positive steer
    run(-800, 5000, 40, -15, "R6");     // negative steer
    run(300, 6000, 90, 60, "R8");       // saturates to +30
    run(300, 6000, 90, 30, "R8");
    run(300, 6000, 90, -64, "R8");      // most negative input
    run(0, 1000, 0, 0, "R9");           // outside cone
    run(0, 864, 73, 0, "R9");           // |dx| == z - Z_START
    run(0, 863, 73, 0, "R9");           // one tick too shallow
    run(0, 40, 63, 0, "R9");            // above minimum depth
    run(0, 24090, 63, 0, "R10");        // near record end
    run(0, 24110, 63, 0, "R10");
    run(0, 30000, 63, 5, "R11");        // past record end
    run(5460, 11000, 0, 0, "R12");      // beyond taper span
    run(0, 8000, 100, 0, "R12");        // mid taper
    run(-9000, 20000, 127, -20, "R12");

    // R3: request during computation and on the result edge
    issue(200, 5000, 50, 10, "R3");
    repeat (4) @(negedge clk);
    ghost(-3000, 9000, 5, -25);
    while (cyc < tgt - 1) @(negedge clk);
    ghost(-3000, 9000, 5, -25);         // lands on the result edge
    issue(-3000, 9000, 5, -25, "R3");   // first edge after done
    waitIdle();

    for (int i = 0; i < 30; i++) begin
      run(int'($urandom_range(16000)) - 8000, 64 + int'($urandom_range(20000)),
          int'($urandom_range(127)), int'($urandom_range(80)) - 40, "R7");
    end

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule